// File: doc/BRIEF.md
# Masked Interrupt Unit with Control Mode

Each processor in a multi-processor system carries one of these units. Every interrupt condition in the system reaches every processor. The local mask register decides which conditions this processor records in its own pending register. The unit watches the pending register and, when a cause is eligible, issues a one-cycle trap. The trap carries a fixed handler vector and the encoded cause, fires a register-save strobe, and puts the processor into a privileged control mode.

While the processor is in control mode, only the high-priority causes can trap, and only a cause that outranks the cause being serviced can do so. Lower-priority causes are still recorded, and they trap as soon as the handler returns to normal mode, provided they are still unmasked. Power failure is recorded and serviced whatever the mask or mode.

Writing the mask, acknowledging a cause, returning from the handler and other privileged operations are allowed only in control mode. If any of them is attempted in normal mode, it has no effect and raises the illegal-operation cause instead.

Top module: `cm_irq_unit`

## Requirements
- R1: During and after reset the unit is in control mode, every pending bit is 0, every mask bit is 1, and trap and restore strobes are low.
- R2: Cause indices are: 0 power fail, 1 power restored, 2 memory/parity fault, 3 illegal operation, 4 bounds violation, 5 arithmetic overflow, 6 I/O done, 7 clock overflow, 8 inter-processor, 9+j external line j. A line sampled high at a clock edge sets its pending bit at that edge only if its mask bit is 1. A masked line leaves the bit at 0.
- R3: A pending bit stays set until an acknowledge in control mode names its index. If the line is still high during the acknowledge, the bit stays set.
- R4: In normal mode, an unmasked pending cause produces a trap one edge after it is latched. The trap is a one-cycle pulse carrying vector 0x0040, with the save strobe high. Control mode is entered at the same edge.
- R5: When several eligible causes are pending, the trap reports the one with the lowest index.
- R6: In control mode, causes with index 6 or above are recorded but never trap.
- R7: In control mode, an unmasked pending cause with index below 6 and below the cause being serviced traps again, pre-empting it.
- R8: Power fail (index 0) is latched with its mask bit at 0 and traps in either mode unless it is already being serviced.
- R9: A mask write takes effect in control mode only. In normal mode the mask is left unchanged.
- R10: The privileged-operation grant is high only in control mode. A privileged operation, mask write, acknowledge or return attempted in normal mode raises cause 3 (if unmasked) and has no other effect.
- R11: A return in control mode switches to normal mode at the next edge and pulses the restore strobe for one cycle.
- R12: Low-priority causes recorded during control mode trap in the first normal-mode cycle after a return if they are unmasked. If they are masked, they stay pending without a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail_i | input | 1 | Primary power failure |
| pwr_up_i | input | 1 | Power restored, restart |
| mem_fault_i | input | 1 | Memory access or parity failure |
| bounds_i | input | 1 | Write outside permitted bounds |
| arith_ovf_i | input | 1 | Arithmetic overflow |
| io_done_i | input | 1 | I/O operation complete |
| rtc_ovf_i | input | 1 | Real-time clock overflow |
| ipi_i | input | 1 | Processor-to-processor signal |
| ext_req_i | input | 16 | External request lines |
| mask_we_i | input | 1 | Mask write request |
| mask_wdata_i | input | 25 | New mask value |
| priv_op_i | input | 1 | Other privileged operation requested (protection set, I/O command) |
| ack_valid_i | input | 1 | Acknowledge request |
| ack_idx_i | input | 5 | Cause index to acknowledge |
| ret_i | input | 1 | Return from handler |
| ctrl_mode_o | output | 1 | High in control mode |
| op_ok_o | output | 1 | Privileged operation granted |
| trap_o | output | 1 | One-cycle trap pulse |
| trap_cause_o | output | 5 | Cause of the latest trap |
| trap_vec_o | output | 16 | Fixed handler vector |
| save_stb_o | output | 1 | Save processor state |
| restore_stb_o | output | 1 | Restore processor state |
| pending_o | output | 25 | Pending register |
| mask_o | output | 25 | Mask register |

## Verification
The bench targets the lockout boundary: a low-priority cause raised in control mode must stay silent and then fire right after the return. A design that ignored the lockout would trap early, and one that forgot the pending bit would never trap. Pre-emption is driven with nested causes of falling index, so a design that compared against the wrong level would either trap repeatedly or miss the higher cause. Power fail is raised with the mask fully cleared, which exposes a design that masks it. Privileged operations attempted in normal mode must leave the mask intact and produce the illegal-operation trap, and an acknowledge with the line still high must not drop the bit.

// File: rtl/cmirq_pkg.sv
`timescale 1ns/1ps
package cmirq_pkg;
   // Cause indices; lower index means higher priority.
   localparam int IDX_PWR_FAIL  = 0;
   localparam int IDX_PWR_UP    = 1;
   localparam int IDX_MEM_FAULT = 2;
   localparam int IDX_ILLEGAL   = 3;
   localparam int IDX_BOUNDS    = 4;
   localparam int IDX_ARITH     = 5;
   localparam int IDX_IO_DONE   = 6;
   localparam int IDX_RTC       = 7;
   localparam int IDX_IPI       = 8;
   localparam int IDX_EXT0      = 9;
   localparam int N_FIXED       = 9;

   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_CTRL   = 1'b1
   } cpu_mode_e;
endpackage

// File: rtl/cmirq_latch.sv
`timescale 1ns/1ps
module cmirq_latch
   import cmirq_pkg::*;
#(
   parameter int NC = 25,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] src_i,
   input  logic          mask_we_i,
   input  logic [NC-1:0] mask_wdata_i,
   input  logic          clr_en_i,
   input  logic [CW-1:0] clr_idx_i,
   output logic [NC-1:0] pend_o,
   output logic [NC-1:0] mask_o
);
   logic [NC-1:0] mask_q;
   logic [NC-1:0] pend_q;
   logic [NC-1:0] set_v;
   logic [NC-1:0] clr_v;

   always_ff @(posedge clk) begin
      if (!rst_n)         mask_q <= '1;
      else if (mask_we_i) mask_q <= mask_wdata_i;
   end

   for (genvar i = 0; i < NC; i++) begin : g_bit
      if (i == IDX_PWR_FAIL) begin : g_nomask
         assign set_v[i] = src_i[i];
      end else begin : g_mask
         assign set_v[i] = src_i[i] & mask_q[i];
      end
      assign clr_v[i] = clr_en_i && (clr_idx_i == CW'(i));
   end

   // a condition still present wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_v) | set_v;
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;

   // R2
   latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_i[IDX_BOUNDS] |=> !pend_q[IDX_BOUNDS] || $past(pend_q[IDX_BOUNDS]));
   // R8
   pwr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_i[IDX_PWR_FAIL] |=> pend_q[IDX_PWR_FAIL]);
endmodule

// File: rtl/cmirq_pick.sv
`timescale 1ns/1ps
module cmirq_pick #(
   parameter int NC = 25,
   parameter int CW = 5
) (
   input  logic [NC-1:0] req_i,
   output logic          any_o,
   output logic [CW-1:0] idx_o
);
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = NC - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = CW'(i);
      end
   end

   // R5
   always_comb begin
      lowest_idx_chk: assert (!any_o || (req_i[idx_o] &&
         ((req_i & ((NC'(1) << idx_o) - NC'(1))) == '0)));
   end
endmodule

// File: rtl/cmirq_mode.sv
`timescale 1ns/1ps
module cmirq_mode
   import cmirq_pkg::*;
#(
   parameter int NC        = 25,
   parameter int CW        = 5,
   parameter int HI_LEVELS = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] pend_i,
   input  logic [NC-1:0] mask_i,
   input  logic          ret_i,
   input  logic          pick_any_i,
   input  logic [CW-1:0] pick_idx_i,
   output logic [NC-1:0] elig_o,
   output logic          ctrl_o,
   output logic          trap_o,
   output logic [CW-1:0] cause_o,
   output logic          restore_o
);
   localparam logic [CW-1:0] NO_LEVEL = CW'(NC);

   cpu_mode_e     mode_q;
   logic [CW-1:0] cur_q;
   logic [CW-1:0] cause_q;
   logic          trap_q;
   logic          restore_q;
   logic          in_ctrl;
   logic          ret_ok;

   assign in_ctrl = (mode_q == MODE_CTRL);
   assign ret_ok  = ret_i && in_ctrl;

   for (genvar i = 0; i < NC; i++) begin : g_elig
      logic base;
      assign base = pend_i[i] & (mask_i[i] | 1'(i == IDX_PWR_FAIL));
      if (i < HI_LEVELS) begin : g_hi
         assign elig_o[i] = base & (!in_ctrl | (CW'(i) < cur_q));
      end else begin : g_lo
         assign elig_o[i] = base & !in_ctrl;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_CTRL;
         cur_q     <= NO_LEVEL;
         cause_q   <= '0;
         trap_q    <= 1'b0;
         restore_q <= 1'b0;
      end else begin
         trap_q    <= 1'b0;
         restore_q <= 1'b0;
         if (ret_ok) begin
            mode_q    <= MODE_NORMAL;
            cur_q     <= NO_LEVEL;
            restore_q <= 1'b1;
         end else if (pick_any_i) begin
            mode_q  <= MODE_CTRL;
            cur_q   <= pick_idx_i;
            cause_q <= pick_idx_i;
            trap_q  <= 1'b1;
         end
      end
   end

   assign ctrl_o    = in_ctrl;
   assign trap_o    = trap_q;
   assign cause_o   = cause_q;
   assign restore_o = restore_q;

   // R6
   lowprio_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> ($past(mode_q) == MODE_NORMAL) || (cause_q < CW'(HI_LEVELS)));
   // R11
   ret_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i && in_ctrl |=> !in_ctrl && restore_q);
   // R8
   pwr_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_i[IDX_PWR_FAIL] && (!in_ctrl || cur_q != '0) && !ret_ok
      |=> trap_q && cause_q == '0);
   // R4
   trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |=> !trap_q || $past(cause_q) > cause_q);
endmodule

// File: rtl/cm_irq_unit.sv
`timescale 1ns/1ps
module cm_irq_unit
   import cmirq_pkg::*;
#(
   parameter int                N_EXT     = 16,
   parameter int                HI_LEVELS = 6,
   parameter int                VEC_W     = 16,
   parameter logic [VEC_W-1:0]  TRAP_VEC  = 16'h0040,
   localparam int               NC        = N_FIXED + N_EXT,
   localparam int               CW        = $clog2(NC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_fail_i,
   input  logic             pwr_up_i,
   input  logic             mem_fault_i,
   input  logic             bounds_i,
   input  logic             arith_ovf_i,
   input  logic             io_done_i,
   input  logic             rtc_ovf_i,
   input  logic             ipi_i,
   input  logic [N_EXT-1:0] ext_req_i,
   input  logic             mask_we_i,
   input  logic [NC-1:0]    mask_wdata_i,
   input  logic             priv_op_i,
   input  logic             ack_valid_i,
   input  logic [CW-1:0]    ack_idx_i,
   input  logic             ret_i,
   output logic             ctrl_mode_o,
   output logic             op_ok_o,
   output logic             trap_o,
   output logic [CW-1:0]    trap_cause_o,
   output logic [VEC_W-1:0] trap_vec_o,
   output logic             save_stb_o,
   output logic             restore_stb_o,
   output logic [NC-1:0]    pending_o,
   output logic [NC-1:0]    mask_o
);
   if (N_EXT < 1 || N_EXT > 32) begin : g_bad_ext
      $error("cm_irq_unit: N_EXT must lie in 1..32");
   end
   if (HI_LEVELS < 1 || HI_LEVELS > N_FIXED) begin : g_bad_hi
      $error("cm_irq_unit: HI_LEVELS must lie in 1..N_FIXED");
   end

   logic [NC-1:0] src;
   logic [NC-1:0] pend;
   logic [NC-1:0] mask;
   logic [NC-1:0] elig;
   logic          pick_any;
   logic [CW-1:0] pick_idx;
   logic          ctrl;
   logic          attempt;
   logic          illegal;

   assign attempt = priv_op_i | mask_we_i | ack_valid_i | ret_i;
   assign illegal = attempt & ~ctrl;

   assign src[IDX_PWR_FAIL]    = pwr_fail_i;
   assign src[IDX_PWR_UP]      = pwr_up_i;
   assign src[IDX_MEM_FAULT]   = mem_fault_i;
   assign src[IDX_ILLEGAL]     = illegal;
   assign src[IDX_BOUNDS]      = bounds_i;
   assign src[IDX_ARITH]       = arith_ovf_i;
   assign src[IDX_IO_DONE]     = io_done_i;
   assign src[IDX_RTC]         = rtc_ovf_i;
   assign src[IDX_IPI]         = ipi_i;
   assign src[NC-1:IDX_EXT0]   = ext_req_i;

   cmirq_latch #(.NC(NC), .CW(CW)) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (src),
      .mask_we_i    (mask_we_i & ctrl),
      .mask_wdata_i (mask_wdata_i),
      .clr_en_i     (ack_valid_i & ctrl),
      .clr_idx_i    (ack_idx_i),
      .pend_o       (pend),
      .mask_o       (mask)
   );

   cmirq_mode #(.NC(NC), .CW(CW), .HI_LEVELS(HI_LEVELS)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend),
      .mask_i     (mask),
      .ret_i      (ret_i),
      .pick_any_i (pick_any),
      .pick_idx_i (pick_idx),
      .elig_o     (elig),
      .ctrl_o     (ctrl),
      .trap_o     (trap_o),
      .cause_o    (trap_cause_o),
      .restore_o  (restore_stb_o)
   );

   cmirq_pick #(.NC(NC), .CW(CW)) u_pick (
      .req_i (elig),
      .any_o (pick_any),
      .idx_o (pick_idx)
   );

   assign ctrl_mode_o = ctrl;
   assign op_ok_o     = priv_op_i & ctrl;
   assign save_stb_o  = trap_o;
   assign trap_vec_o  = TRAP_VEC;
   assign pending_o   = pend;
   assign mask_o      = mask;

   // R9
   mask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i && !ctrl_mode_o |=> $stable(mask_o));
   // R10
   illegal_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attempt && !ctrl_mode_o && mask_o[IDX_ILLEGAL] |=> pending_o[IDX_ILLEGAL]);
   // R4
   trap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> ctrl_mode_o && save_stb_o);
endmodule

// File: tb/cm_irq_unit_tb.sv
`timescale 1ns/1ps
module cm_irq_unit_tb;
   localparam int NC = 25;
   localparam int CW = 5;
   localparam logic [NC-1:0] ALL1 = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_fail_i = 0, pwr_up_i = 0, mem_fault_i = 0, bounds_i = 0;
   logic arith_ovf_i = 0, io_done_i = 0, rtc_ovf_i = 0, ipi_i = 0;
   logic [15:0] ext_req_i = '0;
   logic mask_we_i = 0;
   logic [NC-1:0] mask_wdata_i = '0;
   logic priv_op_i = 0, ack_valid_i = 0, ret_i = 0;
   logic [CW-1:0] ack_idx_i = '0;
   logic ctrl_mode_o, op_ok_o, trap_o, save_stb_o, restore_stb_o;
   logic [CW-1:0] trap_cause_o;
   logic [15:0] trap_vec_o;
   logic [NC-1:0] pending_o, mask_o;

   int checks = 0;
   int errors = 0;
   int exp_q[$];

   always #2 clk = ~clk;

   cm_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail_i), .pwr_up_i(pwr_up_i),
      .mem_fault_i(mem_fault_i), .bounds_i(bounds_i), .arith_ovf_i(arith_ovf_i),
      .io_done_i(io_done_i), .rtc_ovf_i(rtc_ovf_i), .ipi_i(ipi_i),
      .ext_req_i(ext_req_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
      .priv_op_i(priv_op_i), .ack_valid_i(ack_valid_i), .ack_idx_i(ack_idx_i),
      .ret_i(ret_i), .ctrl_mode_o(ctrl_mode_o), .op_ok_o(op_ok_o),
      .trap_o(trap_o), .trap_cause_o(trap_cause_o), .trap_vec_o(trap_vec_o),
      .save_stb_o(save_stb_o), .restore_stb_o(restore_stb_o),
      .pending_o(pending_o), .mask_o(mask_o)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack(int idx);
      ack_valid_i = 1; ack_idx_i = CW'(idx);
      @(negedge clk);
      ack_valid_i = 0;
   endtask

   task automatic do_ret();
      ret_i = 1;
      @(negedge clk);
      chk(!ctrl_mode_o, "R11 normal mode after return", ctrl_mode_o, 0);
      chk(restore_stb_o, "R11 restore strobe", restore_stb_o, 1);
      ret_i = 0;
   endtask

   task automatic wr_mask(logic [NC-1:0] v);
      mask_we_i = 1; mask_wdata_i = v;
      @(negedge clk);
      mask_we_i = 0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      int e;
      if (rst_n && trap_o) begin
         if (exp_q.size() == 0) begin
            chk(0, "R6 unexpected trap", int'(trap_cause_o), -1);
         end else begin
            e = exp_q.pop_front();
            chk(int'(trap_cause_o) == e, "R5 trap cause", int'(trap_cause_o), e);
            chk(trap_vec_o == 16'h0040, "R4 trap vector", int'(trap_vec_o), 64);
            chk(save_stb_o, "R4 save strobe", save_stb_o, 1);
            chk(ctrl_mode_o, "R4 control mode entry", ctrl_mode_o, 1);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(ctrl_mode_o, "R1 control mode", ctrl_mode_o, 1);
      chk(pending_o == '0, "R1 pending clear", int'(pending_o), 0);
      chk(mask_o == ALL1, "R1 mask all ones", int'(mask_o), int'(ALL1));
      chk(!trap_o && !restore_stb_o, "R1 strobes low", trap_o, 0);

      // R6 low-priority recorded, no trap in control mode
      ext_req_i[0] = 1; @(negedge clk); ext_req_i[0] = 0;
      idle(3);
      chk(pending_o[9], "R6 ext0 recorded", pending_o[9], 1);

      // R9 control-mode mask write, R2 masked line ignored
      wr_mask(ALL1 & ~(NC'(1) << 10));
      chk(mask_o == (ALL1 & ~(NC'(1) << 10)), "R9 mask written", int'(mask_o), int'(ALL1 & ~(NC'(1) << 10)));
      ext_req_i[1] = 1; @(negedge clk); ext_req_i[1] = 0;
      idle(2);
      chk(!pending_o[10], "R2 masked line not latched", pending_o[10], 0);

      // R12 recorded cause traps right after return
      exp_q.push_back(9);
      do_ret();
      idle(3);

      // R3 acknowledge semantics
      ack(9); idle(1);
      chk(!pending_o[9], "R3 ack clears", pending_o[9], 0);
      io_done_i = 1; idle(2);
      ack(6); idle(1);
      chk(pending_o[6], "R3 held line keeps bit", pending_o[6], 1);
      io_done_i = 0; ack(6); idle(1);
      chk(!pending_o[6], "R3 ack after line drops", pending_o[6], 0);

      // R7 pre-emption by higher causes
      exp_q.push_back(5);
      arith_ovf_i = 1; @(negedge clk); arith_ovf_i = 0;
      idle(3);
      exp_q.push_back(4);
      bounds_i = 1; io_done_i = 1; @(negedge clk); bounds_i = 0; io_done_i = 0;
      idle(3);
      chk(pending_o[6], "R6 io done recorded while locked", pending_o[6], 1);

      // R8 power fail ignores mask
      wr_mask('0);
      chk(mask_o == '0, "R9 mask cleared", int'(mask_o), 0);
      exp_q.push_back(0);
      pwr_fail_i = 1; @(negedge clk); pwr_fail_i = 0;
      idle(3);
      chk(pending_o[0], "R8 power fail latched", pending_o[0], 1);

      // R12 masked low cause stays quiet after return
      ack(0); ack(4); ack(5);
      do_ret();
      idle(4);
      chk(!ctrl_mode_o, "R12 masked cause no trap", ctrl_mode_o, 0);
      chk(pending_o[6], "R12 masked cause still pending", pending_o[6], 1);

      // R9 normal-mode mask write ignored (illegal masked too)
      wr_mask(ALL1);
      chk(mask_o == '0, "R9 normal write ignored", int'(mask_o), 0);
      idle(2);
      chk(!pending_o[3], "R10 masked illegal not latched", pending_o[3], 0);

      // R8 power fail in normal mode, then R12 unmasked cause after return
      exp_q.push_back(0);
      pwr_fail_i = 1; @(negedge clk); pwr_fail_i = 0;
      idle(3);
      wr_mask(ALL1);
      ack(0);
      exp_q.push_back(6);
      do_ret();
      idle(3);
      ack(6);

      // R10 privilege check
      do_ret();
      idle(2);
      priv_op_i = 1; #1;
      chk(!op_ok_o, "R10 no grant in normal mode", op_ok_o, 0);
      exp_q.push_back(3);
      @(negedge clk); priv_op_i = 0;
      idle(3);
      priv_op_i = 1; #1;
      chk(op_ok_o, "R10 grant in control mode", op_ok_o, 1);
      @(negedge clk); priv_op_i = 0;
      ack(3); idle(1);
      chk(!pending_o[3], "R10 legal op raises nothing", pending_o[3], 0);

      // R9 normal-mode mask write raises illegal, mask kept
      do_ret();
      idle(2);
      exp_q.push_back(3);
      wr_mask('0);
      chk(mask_o == ALL1, "R9 mask unchanged", int'(mask_o), int'(ALL1));
      idle(3);
      ack(3);

      // R5 priority among simultaneous causes, R4 timing
      do_ret();
      idle(2);
      exp_q.push_back(7);
      ext_req_i[15] = 1; ipi_i = 1; rtc_ovf_i = 1;
      @(negedge clk);
      ext_req_i[15] = 0; ipi_i = 0; rtc_ovf_i = 0;
      chk(!trap_o, "R4 no trap at latch edge", trap_o, 0);
      @(negedge clk);
      chk(trap_o, "R4 trap one edge after latch", trap_o, 1);
      idle(2);
      ack(7);
      exp_q.push_back(8);
      do_ret(); idle(3);
      ack(8);
      exp_q.push_back(24);
      do_ret(); idle(3);
      ack(24);
      do_ret(); idle(3);
      chk(!ctrl_mode_o, "R11 stays normal", ctrl_mode_o, 0);
      chk(pending_o == '0, "R3 all acknowledged", int'(pending_o), 0);
      chk(exp_q.size() == 0, "R4 all expected traps taken", exp_q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule